// File: doc/BRIEF.md
# Annealed Recurrent-Neuron Window Decoder

This block decodes a rate 1/2, constraint-length-3 convolutional code with a short window of binary recurrent neurons instead of a trellis search. Each accepted codeword carries two 3-bit soft symbols. The codeword enters a delay line, so every neuron in the window sees the symbol pairs at its own delays. Two neurons before the window hold the two most recent decisions. Two neurons after the window are pinned to logic 0. The free neurons are cleared and then updated together, once per cycle, for a fixed number of sweeps.

Every sweep adds a noise term to each neuron's sum. A noise source outside the block supplies one sign bit per neuron. The block supplies the magnitude, which is the variance code it drives out. That code starts at full scale and falls linearly to zero over the sweeps, which anneals the network out of local minima. After the last sweep, neuron zero is the decoded bit. The window then slides by one codeword and the decided bit becomes the nearest boundary neuron.

Top module: `rnn_window_decoder`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `in_ready` is 1, `dec_valid` is 0 and `var_code` is 0. The symbol delay line and all neuron states are cleared to 0.
- R2: A codeword is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for exactly ITERS cycles. It returns to 1 in the same cycle as `dec_valid`.
- R3: In sweep i (i = 0..ITERS-1, i = 0 being the first cycle after acceptance), `var_code` equals 15 - floor(i*15/(ITERS-1)). While the block is idle, `var_code` is 0.
- R4: A neuron bit b stands for the bipolar value +1 when b is 1 and -1 when b is 0. A soft symbol q stands for 2q-7. Each sweep updates every free neuron k = 0..T at the same time, from the previous states. The sum is -A[k]*S(k-2) + B[k]*S(k-1)*S(k-2) + B[k+1]*S(k+1)*S(k-1) - A[k+2]*S(k+2) + B[k+2]*S(k+1)*S(k+2) + N. N is +`var_code` when `noise_sign[k]` is 1 and -`var_code` when it is 0. The new bit is 1 when the sum is 0 or greater.
- R5: Neurons S(-2) and S(-1) hold the two previous decisions. S(T+1) and S(T+2) are always logic 0. All free neurons are set to 0 when a codeword is accepted.
- R6: `dec_valid` is a one-cycle pulse ITERS cycles after the acceptance edge. `dec_bit` is then the state of neuron 0 after the final sweep.
- R7: The delay line holds T+3 symbol pairs, with the newest at index T+2 and the oldest at index 0. Each acceptance shifts every pair down by one index. A[j] and B[j] are the first and second symbols at index j.
- R8: On a decision, S(-2) takes the old S(-1), and S(-1) takes the decided bit.
- R9: Changes to `in_valid` and to the symbols while the block is busy have no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Codeword offered |
| in_ready | output | 1 | Block idle and able to accept a codeword |
| in_sym_a | input | 3 | First soft symbol of the codeword |
| in_sym_b | input | 3 | Second soft symbol of the codeword |
| noise_sign | input | T+1 | Per-neuron noise sign for the current sweep |
| var_code | output | 4 | Noise magnitude for the current sweep |
| dec_valid | output | 1 | Decision strobe |
| dec_bit | output | 1 | Decoded bit |

## Verification
The assertions assume that `rst` is applied from time zero, and that ITERS is at least 2, so the annealing slope is defined. They assume nothing about how `in_valid` behaves or when the noise signs change, because the block must tolerate any pattern on those inputs. The stimulus changes all inputs only on the falling clock edge. It holds `in_valid` high at random and changes the symbols while the block is busy. It runs three noise regimes: signs all 1, random signs, and signs all 0. One phase feeds hard-valued symbols produced by a real 7,5 encoder.

// File: rtl/rnn_pkg.sv
package rnn_pkg;
  localparam int SYM_W = 3;
  localparam int SYM_OFS = (1 << SYM_W) - 1;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

  // bipolar value 2q - (2^W - 1) of an unsigned soft symbol
  function automatic logic signed [7:0] sym_value(input logic [SYM_W-1:0] q);
    return $signed({{(7-SYM_W){1'b0}}, q, 1'b0}) - 8'(SYM_OFS);
  endfunction
endpackage

// File: rtl/rnn_symbol_window.sv
module rnn_symbol_window
  import rnn_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         shift_en,
  input  logic [SYM_W-1:0]             sym_a,
  input  logic [SYM_W-1:0]             sym_b,
  output logic [DEPTH-1:0][SYM_W-1:0]  tap_a,
  output logic [DEPTH-1:0][SYM_W-1:0]  tap_b
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tap_a <= '0;
      tap_b <= '0;
    end else if (shift_en) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        tap_a[i] <= tap_a[i+1];
        tap_b[i] <= tap_b[i+1];
      end
      tap_a[DEPTH-1] <= sym_a;
      tap_b[DEPTH-1] <= sym_b;
    end
  end
endmodule

// File: rtl/rnn_neuron.sv
module rnn_neuron
  import rnn_pkg::*;
#(
  parameter int VW = 4
) (
  input  logic [SYM_W-1:0] a_here,
  input  logic [SYM_W-1:0] b_here,
  input  logic [SYM_W-1:0] b_next,
  input  logic [SYM_W-1:0] a_next2,
  input  logic [SYM_W-1:0] b_next2,
  input  logic             s_m2,
  input  logic             s_m1,
  input  logic             s_p1,
  input  logic             s_p2,
  input  logic             noise_pos,
  input  logic [VW-1:0]    var_mag,
  output logic             s_new
);
  localparam int SW = VW + 5;

  function automatic logic signed [SW-1:0] signed_term(input logic signed [7:0] v, input logic pos);
    logic signed [SW-1:0] w;
    w = SW'(v);
    return pos ? w : -w;
  endfunction

  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] nz;

  always_comb begin
    nz  = $signed({1'b0, var_mag});
    if (!noise_pos) nz = -nz;
    sum = signed_term(sym_value(a_here), !s_m2)
        + signed_term(sym_value(b_here), s_m1 ~^ s_m2)
        + signed_term(sym_value(b_next), s_p1 ~^ s_m1)
        + signed_term(sym_value(a_next2), !s_p2)
        + signed_term(sym_value(b_next2), s_p1 ~^ s_p2)
        + nz;
    s_new = !sum[SW-1];
  end
endmodule

// File: rtl/rnn_anneal_seq.sv
module rnn_anneal_seq
  import rnn_pkg::*;
#(
  parameter int ITERS = 16,
  parameter int VW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [VW-1:0] var_code,
  output logic          accept,
  output logic          step,
  output logic          last
);
  localparam int IW   = (ITERS > 2) ? $clog2(ITERS) : 1;
  localparam int VMAX = (1 << VW) - 1;
  localparam logic [IW-1:0] LAST_IT = IW'(ITERS - 1);

  function automatic logic [VW-1:0] var_at(input int i);
    return VW'(VMAX - (i * VMAX) / (ITERS - 1));
  endfunction

  seq_state_t    state;
  logic [IW-1:0] iter;

  assign accept = in_valid && in_ready;
  assign step   = (state == SEQ_RUN);
  assign last   = step && (iter == LAST_IT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      iter     <= '0;
      var_code <= '0;
      in_ready <= 1'b1;
    end else if (state == SEQ_IDLE) begin
      if (accept) begin
        state    <= SEQ_RUN;
        iter     <= '0;
        var_code <= VW'(VMAX);
        in_ready <= 1'b0;
      end
    end else if (last) begin
      state    <= SEQ_IDLE;
      iter     <= '0;
      var_code <= '0;
      in_ready <= 1'b1;
    end else begin
      iter     <= iter + 1'b1;
      var_code <= var_at(int'(iter) + 1);
    end
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  assert_var_full_start_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (var_code == VW'(VMAX)));
  assert_var_monotone_R3: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !$past(in_ready)) |-> (var_code <= $past(var_code)));
  assert_idle_var_zero_R3: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (var_code == '0));
endmodule

// File: rtl/rnn_window_decoder.sv
module rnn_window_decoder
  import rnn_pkg::*;
#(
  parameter int WIN_T = 5,
  parameter int ITERS = 16,
  parameter int VW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_sym_a,
  input  logic [SYM_W-1:0] in_sym_b,
  input  logic [WIN_T:0]   noise_sign,
  output logic [VW-1:0]    var_code,
  output logic             dec_valid,
  output logic             dec_bit
);
  localparam int DEPTH = WIN_T + 3;
  localparam int NFREE = WIN_T + 1;
  localparam int NEXT  = WIN_T + 5;

  logic accept, step, last;
  logic [DEPTH-1:0][SYM_W-1:0] tap_a, tap_b;
  logic [NFREE-1:0] s_free, s_next;
  logic s_m1, s_m2;
  logic [NEXT-1:0] s_ext;

  rnn_anneal_seq #(.ITERS(ITERS), .VW(VW)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .var_code(var_code), .accept(accept), .step(step), .last(last)
  );

  rnn_symbol_window #(.DEPTH(DEPTH)) u_win (
    .clk(clk), .rst(rst), .shift_en(accept),
    .sym_a(in_sym_a), .sym_b(in_sym_b), .tap_a(tap_a), .tap_b(tap_b)
  );

  // extended neuron vector: index k+2 holds neuron k
  assign s_ext = {2'b00, s_free, s_m1, s_m2};

  for (genvar k = 0; k < NFREE; k++) begin : g_neuron
    rnn_neuron #(.VW(VW)) u_neuron (
      .a_here(tap_a[k]), .b_here(tap_b[k]), .b_next(tap_b[k+1]),
      .a_next2(tap_a[k+2]), .b_next2(tap_b[k+2]),
      .s_m2(s_ext[k]), .s_m1(s_ext[k+1]), .s_p1(s_ext[k+3]), .s_p2(s_ext[k+4]),
      .noise_pos(noise_sign[k]), .var_mag(var_code), .s_new(s_next[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_free    <= '0;
      s_m1      <= 1'b0;
      s_m2      <= 1'b0;
      dec_valid <= 1'b0;
      dec_bit   <= 1'b0;
    end else begin
      dec_valid <= 1'b0;
      if (accept) s_free <= '0;
      else if (step) s_free <= s_next;
      if (last) begin
        dec_valid <= 1'b1;
        dec_bit   <= s_next[0];
        s_m1      <= s_next[0];
        s_m2      <= s_m1;
      end
    end
  end

  assert_free_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    accept |=> (s_free == '0));
  assert_boundary_slide_R8: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> ((s_m1 == dec_bit) && (s_m2 == $past(s_m1))));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);
  assert_ready_with_decision_R2: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> in_ready);
endmodule

// File: tb/tb_rnn_window_decoder.sv
module tb_rnn_window_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_T = 5;
  localparam int ITERS = 16;
  localparam int VW    = 4;
  localparam int DEPTH = WIN_T + 3;
  localparam int NFREE = WIN_T + 1;
  localparam int VMAX  = 15;
  localparam int PHASE_CYCLES = 600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_sym_a = '0;
  logic [2:0] in_sym_b = '0;
  logic [WIN_T:0] noise_sign = '0;
  logic [VW-1:0] var_code;
  logic dec_valid, dec_bit;

  int checks = 0;
  int failures = 0;
  int n_dec = 0;
  bit done = 0;

  rnn_window_decoder #(.WIN_T(WIN_T), .ITERS(ITERS), .VW(VW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym_a(in_sym_a), .in_sym_b(in_sym_b), .noise_sign(noise_sign),
    .var_code(var_code), .dec_valid(dec_valid), .dec_bit(dec_bit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_a[DEPTH], m_b[DEPTH];
  int m_s[WIN_T+5];
  int m_nxt[NFREE];
  int m_busy, m_iter, m_var, m_ready, m_dv, m_db;

  function automatic int bip(input int b); return b ? 1 : -1; endfunction
  function automatic int sv(input int q);  return 2 * q - 7;  endfunction

  always @(posedge clk) begin : ref_model
    int sum, e;
    if (rst) begin
      foreach (m_a[i]) begin m_a[i] = 0; m_b[i] = 0; end
      foreach (m_s[i]) m_s[i] = 0;
      m_busy = 0; m_iter = 0; m_var = 0; m_ready = 1; m_dv = 0; m_db = 0;
    end else begin
      m_dv = 0;
      if (m_ready != 0 && in_valid) begin
        for (int i = 0; i < DEPTH - 1; i++) begin m_a[i] = m_a[i+1]; m_b[i] = m_b[i+1]; end
        m_a[DEPTH-1] = int'(in_sym_a);
        m_b[DEPTH-1] = int'(in_sym_b);
        for (int k = 0; k < NFREE; k++) m_s[k+2] = 0;
        m_busy = 1; m_iter = 0; m_var = VMAX; m_ready = 0;
      end else if (m_busy != 0) begin
        for (int k = 0; k < NFREE; k++) begin
          e = k + 2;
          sum = -sv(m_a[k]) * bip(m_s[e-2])
              + sv(m_b[k]) * bip(m_s[e-1]) * bip(m_s[e-2])
              + sv(m_b[k+1]) * bip(m_s[e+1]) * bip(m_s[e-1])
              - sv(m_a[k+2]) * bip(m_s[e+2])
              + sv(m_b[k+2]) * bip(m_s[e+1]) * bip(m_s[e+2])
              + (noise_sign[k] ? m_var : -m_var);
          m_nxt[k] = (sum >= 0) ? 1 : 0;
        end
        for (int k = 0; k < NFREE; k++) m_s[k+2] = m_nxt[k];
        if (m_iter == ITERS - 1) begin
          m_dv = 1; m_db = m_nxt[0];
          m_s[0] = m_s[1]; m_s[1] = m_nxt[0];
          m_ready = 1; m_busy = 0; m_var = 0;
        end else begin
          m_iter++;
          m_var = VMAX - (m_iter * VMAX) / (ITERS - 1);
        end
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(int'(in_ready) == m_ready, "R2 in_ready", int'(in_ready), m_ready);
      check(int'(var_code) == m_var, "R3 var_code", int'(var_code), m_var);
      check(int'(dec_valid) == m_dv, "R6 dec_valid", int'(dec_valid), m_dv);
      if (m_dv != 0) begin
        n_dec++;
        check(int'(dec_bit) == m_db, "R4/R5/R7/R8/R9 dec_bit", int'(dec_bit), m_db);
      end
    end
  end

  initial begin : stimulus
    int u1, u2, u;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    check(dec_valid == 1'b0, "R1 reset dec_valid", int'(dec_valid), 0);
    check(var_code == '0, "R1 reset var_code", int'(var_code), 0);
    rst = 1'b0;

    // phase A: noise signs all 1, random symbols, random valid; data churns while busy (R9)
    for (int c = 0; c < PHASE_CYCLES; c++) begin
      @(negedge clk);
      noise_sign = '1;
      in_valid   = ($urandom_range(3) != 0);
      in_sym_a   = 3'($urandom_range(7));
      in_sym_b   = 3'($urandom_range(7));
    end

    // phase B: hard symbols from a 7,5 encoder, random noise signs (R7)
    u1 = 0; u2 = 0;
    in_valid = 1'b0;
    for (int c = 0; c < PHASE_CYCLES; c++) begin
      @(negedge clk);
      noise_sign = (WIN_T+1)'($urandom);
      if (in_ready) begin
        u = $urandom_range(1);
        in_sym_a = ((u ^ u1 ^ u2) != 0) ? 3'd7 : 3'd0;
        in_sym_b = ((u ^ u2) != 0) ? 3'd7 : 3'd0;
        u2 = u1; u1 = u;
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end

    // phase C: noise signs all 0, valid toggling freely while busy (R9)
    for (int c = 0; c < PHASE_CYCLES; c++) begin
      @(negedge clk);
      noise_sign = '0;
      in_valid   = $urandom_range(1) != 0;
      in_sym_a   = 3'($urandom_range(7));
      in_sym_b   = 3'($urandom_range(7));
    end
    in_valid = 1'b0;
    repeat (ITERS + 4) @(negedge clk);

    check(n_dec > 20, "R6 decisions produced", n_dec, 21);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule